// File: doc/BRIEF.md
# Glitchless Clock Output Enable Gate

This block sits between a free-running clock and one clock output pin of a chip. Three shared enable pins, all active low, may be routed to the output. A per-output mask picks which of them count, and any routed pin that asks for disable wins. The gate opens and closes only at the falling edge of the output clock. As a result, no high pulse is ever cut short or started in the middle of a phase.

When gated off, the output parks at a level chosen per output: driven low, driven high, or released (output-enable low). An invert flag turns the output into the complement of the source clock, which is a 180 degree shifted copy. The parked level does not depend on the invert flag. A power-down input silences the output at once. On release, power-down restarts the output through the same clean path as the enable pins.

The combined enable crosses into the clock domain through a short synchronizer. Gating then takes effect at a fixed cycle count after a pin changes, far inside the microsecond-scale limit that an output enable must meet.

Top module: `clkout_gate`

## Requirements
- R1: The enable pins are active low. With every routed pin low and power-down low, the output runs; a routed pin driven high stops it.
- R2: A pin is routed when its bit in `pin_map` is 1 (bit i routes `en_n_pin[i]`). Any routed pin at 1 disables the output. Unrouted pins have no effect.
- R3: Let a change of the combined enable first be seen at rising clock edge k. That change governs the output from the high half-cycle following rising edge k+2: the first full pulse on enabling, or the first parked high half on disabling.
- R4: On enabling, the first output pulse is a complete high phase that begins at an output clock rising edge.
- R5: On disabling, the pulse in progress completes. The gate changes only at output clock falling edges: at clock falling edges when not inverted, and at clock rising edges when inverted.
- R6: The parked state is coded on `park_sel`: 2'b00 drives 0, 2'b01 drives 1, and 2'b10 or 2'b11 releases the pin (`clk_drv`=0, `clk_dat`=0).
- R7: With `inv_en`=1 the running output equals the inverted clock. The parked level is the same as with `inv_en`=0.
- R8: While `pwr_dn` is 1, `clk_drv` and `clk_dat` are both 0 at once. Power-down also counts as a disable request, so after release the output restarts as in R3 and R4.
- R9: During and after synchronous reset the output is parked until an enable has passed through the R3 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock to be gated; also clocks the control logic |
| rst | input | 1 | Synchronous active-high reset |
| en_n_pin | input | NPIN (3) | Shared active-low enable pins |
| pin_map | input | NPIN (3) | Routing mask: bit i set makes en_n_pin[i] control this output |
| park_sel | input | 2 | Parked state code: 00 low, 01 high, 1x released |
| inv_en | input | 1 | Output is the inverted clock when 1 |
| pwr_dn | input | 1 | Active-high power-down, silences the output immediately |
| clk_dat | output | 1 | Output data value |
| clk_drv | output | 1 | Output driver enable (0 means high-impedance) |

## Verification
On every rising edge the assertions check four things. Power-down keeps the pin silent. The rising-edge gate copy equals the combined enable from three edges earlier. The falling-edge copy leads that copy by one edge. A closed gate shows the coded parked level or releases the pin. Whether a pulse is whole can only be seen by sampling both halves of each clock period against the pin history. The bench scenarios do this: single-cycle enables, pins toggling under several masks, inversion switched between runs, and power-down cutting in during a run.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    PARK_LOW     = 2'b00,
    PARK_HIGH    = 2'b01,
    PARK_HIZ     = 2'b10,
    PARK_HIZ_ALT = 2'b11
  } park_e;
endpackage

// File: rtl/clkgate_combine.sv
module clkgate_combine #(
  parameter int NPIN = 3
) (
  input  logic [NPIN-1:0] en_n_pin,
  input  logic [NPIN-1:0] pin_map,
  input  logic            pwr_dn,
  output logic            run_req
);
  logic [NPIN-1:0] stop_vec;

  // A routed pin held high asks for disable; disable dominates.
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign stop_vec[i] = en_n_pin[i] & pin_map[i];
  end

  assign run_req = ~pwr_dn & ~(|stop_vec);
endmodule

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/clkgate_edge.sv
module clkgate_edge (
  input  logic clk,
  input  logic rst,
  input  logic inv_en,
  input  logic d,
  output logic rise_q,
  output logic fall_q,
  output logic gate
);
  // Copy updated while the true clock is low (for the plain output).
  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= d;
  end

  // Copy updated while the inverted clock is low (for the inverted output).
  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= d;
  end

  assign gate = inv_en ? rise_q : fall_q;
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
  import clkgate_pkg::*;
#(
  parameter int NPIN        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] en_n_pin,
  input  logic [NPIN-1:0] pin_map,
  input  logic [1:0]      park_sel,
  input  logic            inv_en,
  input  logic            pwr_dn,
  output logic            clk_dat,
  output logic            clk_drv
);
  logic run_req;
  logic run_sync;
  logic gate_rise_q;
  logic gate_fall_q;
  logic gate_sel;
  logic src_clk;
  park_e park;

  clkgate_combine #(.NPIN(NPIN)) u_comb (
    .en_n_pin (en_n_pin),
    .pin_map  (pin_map),
    .pwr_dn   (pwr_dn),
    .run_req  (run_req)
  );

  clkgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (run_req),
    .q   (run_sync)
  );

  clkgate_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .inv_en (inv_en),
    .d      (run_sync),
    .rise_q (gate_rise_q),
    .fall_q (gate_fall_q),
    .gate   (gate_sel)
  );

  // Inversion sits before the park mux, so the parked level is absolute.
  assign src_clk = clk ^ inv_en;
  assign park    = park_e'(park_sel);

  always_comb begin
    clk_dat = 1'b0;
    clk_drv = 1'b0;
    if (pwr_dn) begin
      clk_dat = 1'b0;
      clk_drv = 1'b0;
    end else if (gate_sel) begin
      clk_dat = src_clk;
      clk_drv = 1'b1;
    end else begin
      unique case (park)
        PARK_LOW:  begin clk_dat = 1'b0; clk_drv = 1'b1; end
        PARK_HIGH: begin clk_dat = 1'b1; clk_drv = 1'b1; end
        default:   begin clk_dat = 1'b0; clk_drv = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
  parameter int NPIN = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NPIN-1:0] en_n_pin,
  input logic [NPIN-1:0] pin_map,
  input logic [1:0]      park_sel,
  input logic            pwr_dn,
  input logic            clk_dat,
  input logic            clk_drv,
  input logic            gate_sel,
  input logic            gate_rise_q,
  input logic            gate_fall_q
);
  logic [1:0] since_rst;
  logic       want_run;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign want_run = !pwr_dn && ((en_n_pin & pin_map) == '0);

  AST_PDN_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |-> (!clk_drv && !clk_dat)); // R8

  AST_EN_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (gate_rise_q == $past(want_run, 3))); // R3

  AST_FALL_LEADS: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (gate_rise_q == $past(gate_fall_q))); // R5

  AST_PARK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && !gate_sel && park_sel == 2'b01) |-> (clk_drv && clk_dat)); // R6

  AST_PARK_LOW: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && !gate_sel && park_sel == 2'b00) |-> (clk_drv && !clk_dat)); // R6

  AST_PARK_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && !gate_sel && park_sel[1]) |-> !clk_drv); // R6
endmodule

bind clkout_gate clkout_gate_chk #(.NPIN(NPIN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_n_pin    (en_n_pin),
  .pin_map     (pin_map),
  .park_sel    (park_sel),
  .pwr_dn      (pwr_dn),
  .clk_dat     (clk_dat),
  .clk_drv     (clk_drv),
  .gate_sel    (gate_sel),
  .gate_rise_q (gate_rise_q),
  .gate_fall_q (gate_fall_q)
);

// File: tb/tb_clkout_gate.sv
`timescale 1ns/1ps
module tb_clkout_gate;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] pins;
  logic [2:0] map;
  logic [1:0] park;
  logic       inv;
  logic       pdn;
  logic       clk_dat;
  logic       clk_drv;

  int    errors = 0;
  int    checks = 0;
  logic  mon_on = 1'b0;
  logic  h0, h1, h2;
  string tag = "R9";

  always #5 clk = ~clk;

  clkout_gate dut (
    .clk      (clk),
    .rst      (rst),
    .en_n_pin (pins),
    .pin_map  (map),
    .park_sel (park),
    .inv_en   (inv),
    .pwr_dn   (pdn),
    .clk_dat  (clk_dat),
    .clk_drv  (clk_drv)
  );

  // History of the combined enable as seen at each rising edge (R1, R2, R8).
  always @(posedge clk) begin
    if (rst) begin
      h0 <= 1'b0; h1 <= 1'b0; h2 <= 1'b0;
    end else begin
      h2 <= h1;
      h1 <= h0;
      h0 <= !pdn && ((pins & map) == 3'b000);
    end
  end

  function automatic logic [1:0] model(input logic hi, input logic run,
                                       input logic iv, input logic [1:0] pk,
                                       input logic pd);
    if (pd)  return 2'b00;                 // R8
    if (run) return {1'b1, hi ^ iv};       // R4 R7
    case (pk)                              // R6
      2'b00:   return 2'b10;
      2'b01:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic sample(input logic hi);
    logic       run;
    logic [1:0] exp_v;
    // R3 R5: high half follows the edge two back; low half per output edge.
    run   = hi ? h2 : (inv ? h2 : h1);
    exp_v = model(hi, run, inv, park, pdn);
    checks++;
    if ({clk_drv, clk_dat} !== exp_v) begin
      errors++;
      $display("FAIL %s t=%0t half=%0d actual drv/dat=%b expected=%b",
               tag, $time, hi, {clk_drv, clk_dat}, exp_v);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) sample(1'b1);
      #5;
      if (mon_on) sample(1'b0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    rst = 1'b1; pins = 3'b111; map = 3'b111; park = 2'b01; inv = 1'b0; pdn = 1'b0;
    cyc(2);
    mon_on = 1'b1;                 // R9: parked high during reset
    cyc(2);
    rst = 1'b0;
    cyc(5);                        // R9: still parked after reset

    tag = "R1"; pins = 3'b000; cyc(6);
    pins = 3'b100; cyc(6);
    pins = 3'b000; cyc(4);

    tag = "R2"; map = 3'b001; pins = 3'b110; cyc(6);   // unrouted highs ignored
    pins = 3'b111; cyc(6);
    map = 3'b011; pins = 3'b010; cyc(6);                // any routed high wins
    map = 3'b000; pins = 3'b111; cyc(6);

    tag = "R4"; map = 3'b111; pins = 3'b111; cyc(4);
    pins = 3'b000; cyc(1); pins = 3'b111; cyc(6);       // single-cycle enable
    tag = "R5"; park = 2'b00;
    repeat (4) begin pins = 3'b000; cyc(2); pins = 3'b001; cyc(2); end
    cyc(4);

    tag = "R6"; park = 2'b00; cyc(4); park = 2'b10; cyc(4);
    park = 2'b11; cyc(4); park = 2'b01; cyc(4);

    tag = "R7"; inv = 1'b1; park = 2'b00; pins = 3'b000; cyc(6);
    pins = 3'b010; cyc(5); park = 2'b01; cyc(3);
    pins = 3'b000; cyc(1); pins = 3'b111; cyc(6);
    inv = 1'b0;

    tag = "R8"; pins = 3'b000; cyc(6); pdn = 1'b1; cyc(5);
    pdn = 1'b0; cyc(6);

    tag = "R3";
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(2, 0) == 0)  pins = 3'($urandom_range(7, 0));
      if ($urandom_range(15, 0) == 0) map  = 3'($urandom_range(7, 0));
      if ($urandom_range(15, 0) == 0) park = 2'($urandom_range(3, 0));
      if ($urandom_range(31, 0) == 0) inv  = ~inv;
      if ($urandom_range(39, 0) == 0) pdn  = ~pdn;
      cyc(1);
    end
    pdn = 1'b0; cyc(3);
    mon_on = 1'b0;
    if (seed == 0) cyc(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule